// File: doc/BRIEF.md
# Processor Sleep and Wake Controller

This block decides when a small processor core may stop its clocks and when it must start again. Software writes a small control word that holds a sleep-enable flag and a three-bit mode number. When the core then raises its sleep strobe, the controller samples the mode once and latches a mask of the clock domains to stop. It drops the matching clock-enable outputs and holds the core halted. Five domains are managed: core, program memory, peripheral I/O, converter and asynchronous timer. Mode 000 is the light idle mode. It stops only the core and program-memory clocks. The other encodings come from a parameter table of per-domain gate masks.

While the core sleeps, the controller watches two inputs: a combined "enabled interrupt pending" line and a reset request. An interrupt starts a wake sequence. The gating stays in place for a parameterised oscillator start-up time. All clocks then run again while the core stays halted for four more cycles before it is released. A reset request releases the core at once and records the wake as a reset, so the core restarts from its reset vector. A two-bit cause output reports which path was taken. When idle mode is entered with the converter enabled, a single-cycle start pulse launches a conversion. The controller has no path that clears the core's registers or memory.

Top module: `psc_sleep_ctrl`

## Requirements
- R1: A write strobe loads the 4-bit control word (bit 3 = sleep enable, bits 2:0 = mode), and the new value governs sleep strobes from the next cycle on. After reset the word is 0000, every clock enable is 1, the halt output is 0, the pulse output is 0 and the cause output is 00.
- R2: A sleep strobe while the enable bit is 0 is ignored. The halt output stays 0 and all five clock enables stay 1.
- R3: A sleep strobe with the enable bit at 1 and no pending interrupt puts the block to sleep. From the next cycle the halt output is 1 and the clock enables equal the inverse of the chosen mode's gate mask.
- R4: In mode 000, enables bit 0 (core) and bit 1 (program memory) are 0, and bit 2 (I/O), bit 3 (converter) and bit 4 (asynchronous) stay 1.
- R5: Modes 001 to 111 take their gate mask from the table (bit set = domain stopped). By default 001 stops bits 0 to 3 and 010 stops all five bits. A table entry of zero marks an unused mode, which behaves exactly as idle.
- R6: An interrupt sampled while asleep keeps the halt output at 1 for exactly START_CYC + 4 cycles after that edge. The clock enables stay at the sleep mask for the first START_CYC cycles and are all 1 for the last four. The halt output is then 0.
- R7: A reset request sampled while asleep or during a wake sequence sets the halt output to 0, all enables to 1 and the cause output to 10 in the next cycle. It wins over an interrupt in the same cycle.
- R8: An interrupt in the same cycle as an enabled sleep strobe cancels sleep entry. Nothing changes at the outputs.
- R9: While the core runs, the interrupt and reset-request inputs have no effect on any output.
- R10: The conversion start output pulses for exactly one cycle, the first sleeping cycle, only when the entered mode is idle-class and the converter-enable input is 1.
- R11: The cause output becomes 01 in the cycle after an interrupt wake is sampled. It holds its last value while running and returns to 00 on the next sleep entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, never gated |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 4 | Control word: bit 3 enable, bits 2:0 mode |
| sleep_req | input | 1 | Sleep strobe from the core |
| irq_any | input | 1 | Any enabled interrupt pending |
| rst_req | input | 1 | Reset request for the core |
| adc_en | input | 1 | Converter is enabled |
| clk_en | output | 5 | Per-domain clock enables (0 core, 1 memory, 2 I/O, 3 converter, 4 async) |
| core_halt | output | 1 | Holds the core stopped |
| adc_start | output | 1 | One-cycle conversion start pulse |
| wake_cause | output | 2 | 00 none, 01 interrupt, 10 reset |

## Verification
The bench builds the controller with START_CYC set to 3 and keeps the default gate table. A start-up window that short lets every cycle of an interrupt wake be listed on its own: three gated cycles and four ungated halt cycles, with the release on the exact edge. The default table provides one partly gated mode, one fully gated mode and the unused codes 011 to 111. That covers the mask path and the fallback to idle, including the conversion pulse fired from an unused code.

// File: rtl/psc_pkg.sv
`timescale 1ns/1ps
package psc_pkg;
    localparam int NDOM    = 5;
    localparam int MODE_W  = 3;
    localparam int NMODE   = 1 << MODE_W;
    localparam int HALT_CYC = 4;

    localparam int DOM_CPU = 0;
    localparam int DOM_MEM = 1;
    localparam int DOM_IO  = 2;
    localparam int DOM_ADC = 3;
    localparam int DOM_ASY = 4;

    typedef logic [NDOM-1:0] dmask_t;

    localparam dmask_t IDLE_MASK = dmask_t'((1 << DOM_CPU) | (1 << DOM_MEM));

    // Mode m occupies bits [m*NDOM +: NDOM]; zero entry = unused mode.
    localparam logic [NMODE*NDOM-1:0] DEF_GATE_TBL =
        {25'b0, 5'b11111, 5'b01111, 5'b00011};

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_START = 2'd2,
        ST_HALT  = 2'd3
    } pstate_e;

    localparam logic [1:0] CAUSE_NONE = 2'b00;
    localparam logic [1:0] CAUSE_IRQ  = 2'b01;
    localparam logic [1:0] CAUSE_RST  = 2'b10;

    typedef struct packed {
        logic              se;
        logic [MODE_W-1:0] mode;
    } cfg_t;
endpackage

// File: rtl/psc_cfg_reg.sv
`timescale 1ns/1ps
module psc_cfg_reg
    import psc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [MODE_W:0]     wdata,
    output cfg_t                cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d = cfg_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    AST_CFG_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg_q == cfg_t'($past(wdata)))); // R1
endmodule

// File: rtl/psc_gate_dec.sv
`timescale 1ns/1ps
module psc_gate_dec
    import psc_pkg::*;
#(
    parameter logic [NMODE*NDOM-1:0] GATE_TBL = DEF_GATE_TBL
)
(
    input  logic [MODE_W-1:0] mode,
    output dmask_t            gate,
    output logic              idle_cls
);
    dmask_t           tbl    [NMODE];
    logic [NMODE-1:0] idle_v;

    for (genvar m = 0; m < NMODE; m++) begin : g_ent
        localparam dmask_t RAW = GATE_TBL[m*NDOM +: NDOM];
        if (m == 0 || RAW == '0) begin : g_idle
            assign tbl[m]    = IDLE_MASK;
            assign idle_v[m] = 1'b1;
        end else begin : g_tbl
            assign tbl[m]    = RAW;
            assign idle_v[m] = 1'b0;
        end
    end

    assign gate     = tbl[mode];
    assign idle_cls = idle_v[mode];
endmodule

// File: rtl/psc_wake_seq.sv
`timescale 1ns/1ps
module psc_wake_seq
    import psc_pkg::*;
#(
    parameter int START_CYC = 16
)
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        se,
    input  logic        sleep_req,
    input  logic        irq,
    input  logic        rst_req,
    input  dmask_t      gate,
    input  logic        idle_cls,
    input  logic        adc_en,
    output dmask_t      clk_en,
    output logic        core_halt,
    output logic        adc_start,
    output logic [1:0]  wake_cause
);
    localparam int CNT_MAX = (START_CYC > HALT_CYC) ? START_CYC : HALT_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        pstate_e        st;
        logic [CW-1:0]  cnt;
        dmask_t         mask;
        logic           adc;
        logic [1:0]     cause;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d     = q;
        d.adc = 1'b0;
        unique case (q.st)
            ST_RUN: begin
                if (sleep_req && se && !irq) begin
                    d.st    = ST_SLEEP;
                    d.mask  = gate;
                    d.cause = CAUSE_NONE;
                    d.adc   = adc_en && idle_cls;
                end
            end
            ST_SLEEP: begin
                if (rst_req) begin
                    d.st    = ST_RUN;
                    d.cause = CAUSE_RST;
                end else if (irq) begin
                    d.st    = ST_START;
                    d.cnt   = CW'(START_CYC - 1);
                    d.cause = CAUSE_IRQ;
                end
            end
            ST_START: begin
                if (rst_req) begin
                    d.st    = ST_RUN;
                    d.cause = CAUSE_RST;
                end else if (q.cnt == '0) begin
                    d.st  = ST_HALT;
                    d.cnt = CW'(HALT_CYC - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_HALT: begin
                if (rst_req) begin
                    d.st    = ST_RUN;
                    d.cause = CAUSE_RST;
                end else if (q.cnt == '0) begin
                    d.st = ST_RUN;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_RUN, cnt: '0, mask: '0, adc: 1'b0, cause: CAUSE_NONE};
        end else begin
            q <= d;
        end
    end

    assign clk_en     = (q.st == ST_SLEEP || q.st == ST_START) ? ~q.mask : '1;
    assign core_halt  = (q.st != ST_RUN);
    assign adc_start  = q.adc;
    assign wake_cause = q.cause;

    // Halt-length observer for the interrupt wake window.
    logic [31:0] hlen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hlen_q <= '0;
        end else if (q.st == ST_SLEEP) begin
            hlen_q <= '0;
        end else if (core_halt) begin
            hlen_q <= hlen_q + 1'b1;
        end
    end

    AST_IRQ_WAKE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(core_halt) && wake_cause == CAUSE_IRQ)
            |-> (hlen_q == 32'(START_CYC + HALT_CYC))); // R6
    AST_RST_WAKE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (core_halt && rst_req) |=> (!core_halt && wake_cause == CAUSE_RST && &clk_en)); // R7
    AST_NO_SE_NO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_halt && !se) |=> !core_halt); // R2
    AST_IRQ_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_halt && sleep_req && irq) |=> !core_halt); // R8
    AST_IDLE_DOMAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_halt && sleep_req && se && !irq && idle_cls)
            |=> (!clk_en[DOM_CPU] && !clk_en[DOM_MEM] && clk_en[DOM_IO]
                 && clk_en[DOM_ADC] && clk_en[DOM_ASY])); // R4
    AST_ADC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start); // R10
endmodule

// File: rtl/psc_sleep_ctrl.sv
`timescale 1ns/1ps
module psc_sleep_ctrl
    import psc_pkg::*;
#(
    parameter int                      START_CYC = 16,
    parameter logic [NMODE*NDOM-1:0]   GATE_TBL  = DEF_GATE_TBL
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [MODE_W:0]   cfg_wdata,
    input  logic              sleep_req,
    input  logic              irq_any,
    input  logic              rst_req,
    input  logic              adc_en,
    output logic [NDOM-1:0]   clk_en,
    output logic              core_halt,
    output logic              adc_start,
    output logic [1:0]        wake_cause
);
    cfg_t   cfg;
    dmask_t gate;
    logic   idle_cls;

    psc_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    psc_gate_dec #(
        .GATE_TBL (GATE_TBL)
    ) u_dec (
        .mode     (cfg.mode),
        .gate     (gate),
        .idle_cls (idle_cls)
    );

    psc_wake_seq #(
        .START_CYC (START_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .se         (cfg.se),
        .sleep_req  (sleep_req),
        .irq        (irq_any),
        .rst_req    (rst_req),
        .gate       (gate),
        .idle_cls   (idle_cls),
        .adc_en     (adc_en),
        .clk_en     (clk_en),
        .core_halt  (core_halt),
        .adc_start  (adc_start),
        .wake_cause (wake_cause)
    );

    AST_RUN_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
        !core_halt |-> &clk_en); // R9
    AST_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!core_halt) && !core_halt) |-> $stable(wake_cause)); // R11
endmodule

// File: tb/tb_psc_sleep_ctrl.sv
`timescale 1ns/1ps
module tb_psc_sleep_ctrl;
    localparam int START = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_wdata = '0;
    logic       sleep_req = 1'b0;
    logic       irq_any = 1'b0;
    logic       rst_req = 1'b0;
    logic       adc_en = 1'b0;
    logic [4:0] clk_en;
    logic       core_halt;
    logic       adc_start;
    logic [1:0] wake_cause;

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic [4:0] en;
        logic       h;
        logic       a;
        logic [1:0] c;
    } exp_t;

    exp_t  exp_q[$];
    string rq_q[$];

    always #2.5 clk = ~clk;

    psc_sleep_ctrl #(.START_CYC(START)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .sleep_req(sleep_req), .irq_any(irq_any), .rst_req(rst_req),
        .adc_en(adc_en), .clk_en(clk_en), .core_halt(core_halt),
        .adc_start(adc_start), .wake_cause(wake_cause)
    );

    task automatic compare(input exp_t e, input string rq);
        checks++;
        if (clk_en !== e.en || core_halt !== e.h || adc_start !== e.a || wake_cause !== e.c) begin
            errors++;
            $display("FAIL %s: got en=%b halt=%b adc=%b cause=%b expected en=%b halt=%b adc=%b cause=%b",
                     rq, clk_en, core_halt, adc_start, wake_cause, e.en, e.h, e.a, e.c);
        end
    endtask

    // Monitor: pops one expected item per edge, samples 1 ns after it.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            compare(exp_q.pop_front(), rq_q.pop_front());
        end
    end

    // Driver: inputs applied at the falling edge, expectation for the outputs after the next rising edge.
    task automatic step(input logic we, input logic [3:0] wd, input logic slp,
                        input logic irq, input logic rst, input logic adc,
                        input logic [4:0] en, input logic h, input logic a,
                        input logic [1:0] c, input string rq);
        cfg_we = we; cfg_wdata = wd; sleep_req = slp;
        irq_any = irq; rst_req = rst; adc_en = adc;
        exp_q.push_back('{en: en, h: h, a: a, c: c});
        rq_q.push_back(rq);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got hung run expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare('{en: 5'b11111, h: 1'b0, a: 1'b0, c: 2'b00}, "R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);

        step(0, 4'h0, 1, 0, 0, 1, 5'b11111, 0, 0, 2'b00, "R2 strobe with enable clear");
        step(1, 4'b1000, 0, 0, 0, 1, 5'b11111, 0, 0, 2'b00, "R1 write enable mode 000");
        step(0, 4'h0, 1, 1, 0, 1, 5'b11111, 0, 0, 2'b00, "R8 interrupt cancels entry");
        step(0, 4'h0, 1, 0, 0, 1, 5'b11100, 1, 1, 2'b00, "R3 R4 R10 idle entry");
        step(0, 4'h0, 0, 0, 0, 1, 5'b11100, 1, 0, 2'b00, "R10 pulse lasts one cycle");
        step(0, 4'h0, 0, 0, 0, 1, 5'b11100, 1, 0, 2'b00, "R4 idle holds");
        // R6 interrupt wake: START gated cycles then 4 ungated halt cycles
        step(0, 4'h0, 0, 1, 0, 1, 5'b11100, 1, 0, 2'b01, "R6 R11 wake starts");
        for (int i = 1; i < START; i++)
            step(0, 4'h0, 0, 0, 0, 1, 5'b11100, 1, 0, 2'b01, "R6 start-up window gated");
        for (int i = 0; i < 4; i++)
            step(0, 4'h0, 0, 0, 0, 1, 5'b11111, 1, 0, 2'b01, "R6 four halt cycles");
        step(0, 4'h0, 0, 0, 0, 1, 5'b11111, 0, 0, 2'b01, "R6 core released");
        step(0, 4'h0, 0, 0, 0, 1, 5'b11111, 0, 0, 2'b01, "R11 cause holds");
        step(0, 4'h0, 0, 1, 0, 1, 5'b11111, 0, 0, 2'b01, "R9 interrupt while running");
        step(0, 4'h0, 0, 0, 1, 1, 5'b11111, 0, 0, 2'b01, "R9 reset request while running");

        // R5 mode 001 stops bits 0..3, no conversion pulse outside idle
        step(1, 4'b1001, 0, 0, 0, 1, 5'b11111, 0, 0, 2'b01, "R1 write mode 001");
        step(0, 4'h0, 1, 0, 0, 1, 5'b10000, 1, 0, 2'b00, "R5 R10 R11 mode 001 entry");
        step(0, 4'h0, 0, 1, 1, 1, 5'b11111, 0, 0, 2'b10, "R7 reset beats interrupt");
        step(0, 4'h0, 0, 0, 0, 1, 5'b11111, 0, 0, 2'b10, "R7 cause holds");

        // R5 mode 010 stops everything
        step(1, 4'b1010, 0, 0, 0, 1, 5'b11111, 0, 0, 2'b10, "R1 write mode 010");
        step(0, 4'h0, 1, 0, 0, 1, 5'b00000, 1, 0, 2'b00, "R5 mode 010 entry");
        step(0, 4'h0, 0, 0, 1, 0, 5'b11111, 0, 0, 2'b10, "R7 reset wake");

        // R5 unused mode 101 behaves as idle, including the pulse
        step(1, 4'b1101, 0, 0, 0, 1, 5'b11111, 0, 0, 2'b10, "R1 write mode 101");
        step(0, 4'h0, 1, 0, 0, 1, 5'b11100, 1, 1, 2'b00, "R5 R10 unused mode as idle");
        step(0, 4'h0, 0, 1, 0, 1, 5'b11100, 1, 0, 2'b01, "R6 wake starts again");
        step(0, 4'h0, 0, 0, 1, 1, 5'b11111, 0, 0, 2'b10, "R7 reset inside start-up");

        // R10 idle without converter enabled: no pulse
        step(1, 4'b1000, 0, 0, 0, 0, 5'b11111, 0, 0, 2'b10, "R1 write mode 000");
        step(0, 4'h0, 1, 0, 0, 0, 5'b11100, 1, 0, 2'b00, "R10 no pulse when converter off");
        step(0, 4'h0, 0, 0, 1, 0, 5'b11111, 0, 0, 2'b10, "R7 reset wake from idle");

        // R2 clearing enable blocks a later strobe
        step(1, 4'b0000, 0, 0, 0, 0, 5'b11111, 0, 0, 2'b10, "R1 clear enable");
        step(0, 4'h0, 1, 0, 0, 0, 5'b11111, 0, 0, 2'b10, "R2 strobe ignored");

        wait (exp_q.size() == 0);
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule